// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small microcontroller data path. Each cycle it takes an operation code, the accumulator value, a second operand (a data memory byte or an immediate) and the current carry and half-carry flags. It computes an 8-bit result, new values for the carry (C), half-carry (AC), zero (Z) and overflow (OV) flags, one update enable per flag, and a skip decision for the conditional-skip instructions. Register storage, fetch and decode sit outside the block. The surrounding core writes back only the flags whose enable is set.

Subtraction follows the no-borrow convention. C and AC are set when no borrow occurs. Subtract-with-borrow uses the incoming carry as the inverse of the borrow. All outputs are registered, so the result of an operation presented in one cycle appears after the next rising clock edge.

Top module: `alu8_core`

## Requirements
- R1: All outputs are registered with a latency of one clock. A synchronous active-high reset clears the result, every flag, every enable and the skip output.
- R2: Add (code 0) and add-with-carry (code 1, adds c_i as well) produce the 8-bit sum. C is the carry out of bit 7, AC is the carry out of bit 3, Z is set for a zero result, and upd_o is 4'b1111. The upd_o bit order is [3]=C, [2]=AC, [1]=Z, [0]=OV.
- R3: Subtract (code 2) produces acc_i - opd_i. Subtract-with-borrow (code 3) produces acc_i - opd_i - (1 - c_i). C is set when no borrow occurs. AC is set when the low nibble needs no borrow from the high nibble. All four enables are set.
- R4: For codes 0 to 3, OV is set exactly when the carry into bit 7 differs from the carry out of bit 7.
- R5: Decimal adjust (code 4) works on acc_i. It adds 06h when the low nibble exceeds 9 or ac_i is set. It adds 60h when the original high nibble exceeds 9 or c_i is set. C is the carry out of that addition, and only C is enabled.
- R6: AND (5), OR (6) and XOR (7) combine acc_i with opd_i. Complement (8) inverts opd_i and ignores acc_i. These operations enable only Z.
- R7: Rotate left (9) and rotate right (10) rotate opd_i within its 8 bits, ignore c_i, and enable no flag.
- R8: Rotate left through carry (11) and rotate right through carry (12) shift c_i into the vacated bit. They return the bit shifted out on C, and only C is enabled.
- R9: Increment (13) and decrement (14) of opd_i wrap modulo 256 and enable only Z.
- R10: Skip-if-zero (15) and skip-if-nonzero (16) pass opd_i through as the result and raise skip_o when the operand is zero or non-zero respectively. They enable no flag.
- R11: Increment-and-skip (17) and decrement-and-skip (18) return opd_i plus or minus one and raise skip_o when that new value is zero. They enable no flag.
- R12: A flag output whose enable is low reads 0. skip_o is low for every code other than 15 to 18. Codes 19 to 31 give a zero result with no enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code (see requirements) |
| acc_i | input | 8 | Accumulator operand |
| opd_i | input | 8 | Memory or immediate operand |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current half-carry flag |
| res_o | output | 8 | Registered result |
| c_o | output | 1 | New carry flag |
| ac_o | output | 1 | New half-carry flag |
| z_o | output | 1 | New zero flag |
| ov_o | output | 1 | New overflow flag |
| upd_o | output | 4 | Flag update enables {C, AC, Z, OV} |
| skip_o | output | 1 | Skip next instruction |

## Verification
Increment-and-skip and decrement-and-skip produce a write-back value and a skip decision in the same cycle, and both come from the one stepped operand. The bench drives these codes with operands that wrap through zero (FFh up, 01h down) and with operands that do not. In each case it checks the registered result and skip_o in the same sample. A second overlap is carry and overflow rising together: 80h + 80h must give C, Z and OV together.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBC = 5'd3,
    OP_DAA = 5'd4,
    OP_AND = 5'd5,
    OP_OR  = 5'd6,
    OP_XOR = 5'd7,
    OP_CPL = 5'd8,
    OP_RL  = 5'd9,
    OP_RR  = 5'd10,
    OP_RLC = 5'd11,
    OP_RRC = 5'd12,
    OP_INC = 5'd13,
    OP_DEC = 5'd14,
    OP_SZ  = 5'd15,
    OP_SNZ = 5'd16,
    OP_SIZ = 5'd17,
    OP_SDZ = 5'd18
  } op_e;

  // flag vector order shared by values and enables
  typedef struct packed {
    logic c;
    logic ac;
    logic z;
    logic ov;
  } flags_t;

  localparam int NIB = 4;

endpackage

// File: rtl/alu8_adder.sv
// Ripple adder that exposes the internal carries needed for the
// half-carry and overflow flags.
module alu8_adder #(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          half,
  output logic          into_msb
);

  logic [DW:0] cy;

  assign cy[0] = cin;

  genvar i;
  generate
    for (i = 0; i < DW; i++) begin : g_bit
      assign sum[i]  = x[i] ^ y[i] ^ cy[i];
      assign cy[i+1] = (x[i] & y[i]) | (x[i] & cy[i]) | (y[i] & cy[i]);
    end
  endgenerate

  assign cout     = cy[DW];
  assign half     = cy[NIB];
  assign into_msb = cy[DW-1];

endmodule

// File: rtl/alu8_logic.sv
// Bitwise operations; complement acts on the second operand only.
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] r
);

  always_comb begin
    unique case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_CPL:  r = ~b;
      default: r = '0;
    endcase
  end

endmodule

// File: rtl/alu8_rot.sv
// Plain and through-carry rotates of the second operand.
module alu8_rot
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] r,
  output logic          cout
);

  always_comb begin
    r    = '0;
    cout = 1'b0;
    unique case (op)
      OP_RL:  r = {b[DW-2:0], b[DW-1]};
      OP_RR:  r = {b[0], b[DW-1:1]};
      OP_RLC: begin
        r    = {b[DW-2:0], cin};
        cout = b[DW-1];
      end
      OP_RRC: begin
        r    = {cin, b[DW-1:1]};
        cout = b[0];
      end
      default: begin
        r    = '0;
        cout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_daa.sv
// Decimal adjust: builds the correction constant and adds it.
module alu8_daa #(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic          acin,
  output logic [DW-1:0] r,
  output logic          cout
);

  localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
  localparam logic [NIB-1:0] FIX       = NIB'(6);

  logic [DW-1:0] adj;
  logic          lo_fix;
  logic          hi_fix;
  logic          unused_half;
  logic          unused_msb;

  assign lo_fix = (a[NIB-1:0] > DIGIT_MAX) | acin;
  assign hi_fix = (a[2*NIB-1:NIB] > DIGIT_MAX) | cin;

  always_comb begin
    adj = '0;
    if (lo_fix) adj[NIB-1:0]     = FIX;
    if (hi_fix) adj[2*NIB-1:NIB] = FIX;
  end

  alu8_adder #(.DW(DW), .NIB(NIB)) u_fix_add (
    .x        (a),
    .y        (adj),
    .cin      (1'b0),
    .sum      (r),
    .cout     (cout),
    .half     (unused_half),
    .into_msb (unused_msb)
  );

endmodule

// File: rtl/alu8_core.sv
// Top: operation select, flag enables, skip decision, output registers.
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opd_i,
  input  logic          c_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          ac_o,
  output logic          z_o,
  output logic          ov_o,
  output logic [3:0]    upd_o,
  output logic          skip_o
);

  localparam logic [DW-1:0] ONE = DW'(1);

  op_e op;
  assign op = op_e'(op_i);

  // shared add/subtract path
  logic          is_sub;
  logic [DW-1:0] ad_y;
  logic          ad_cin;
  logic [DW-1:0] ad_sum;
  logic          ad_cout;
  logic          ad_half;
  logic          ad_msb;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SBC);
    ad_y   = is_sub ? ~opd_i : opd_i;
    unique case (op)
      OP_SUB:         ad_cin = 1'b1;
      OP_ADC, OP_SBC: ad_cin = c_i;
      default:        ad_cin = 1'b0;
    endcase
  end

  alu8_adder #(.DW(DW), .NIB(NIB)) u_main_add (
    .x        (acc_i),
    .y        (ad_y),
    .cin      (ad_cin),
    .sum      (ad_sum),
    .cout     (ad_cout),
    .half     (ad_half),
    .into_msb (ad_msb)
  );

  logic [DW-1:0] daa_r;
  logic          daa_c;

  alu8_daa #(.DW(DW), .NIB(NIB)) u_daa (
    .a    (acc_i),
    .cin  (c_i),
    .acin (ac_i),
    .r    (daa_r),
    .cout (daa_c)
  );

  logic [DW-1:0] lg_r;

  alu8_logic #(.DW(DW)) u_logic (
    .op (op),
    .a  (acc_i),
    .b  (opd_i),
    .r  (lg_r)
  );

  logic [DW-1:0] rot_r;
  logic          rot_c;

  alu8_rot #(.DW(DW)) u_rot (
    .op   (op),
    .b    (opd_i),
    .cin  (c_i),
    .r    (rot_r),
    .cout (rot_c)
  );

  logic [DW-1:0] inc_r;
  logic [DW-1:0] dec_r;
  assign inc_r = opd_i + ONE;
  assign dec_r = opd_i - ONE;

  // next-state selection
  logic [DW-1:0] res_n;
  flags_t        flg_n;
  flags_t        en_n;
  logic          skip_n;

  always_comb begin
    res_n  = '0;
    flg_n  = '0;
    en_n   = '0;
    skip_n = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_n    = ad_sum;
        flg_n.c  = ad_cout;
        flg_n.ac = ad_half;
        flg_n.z  = (ad_sum == '0);
        flg_n.ov = ad_msb ^ ad_cout;
        en_n     = 4'b1111;
      end
      OP_DAA: begin
        res_n   = daa_r;
        flg_n.c = daa_c;
        en_n.c  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL: begin
        res_n   = lg_r;
        flg_n.z = (lg_r == '0);
        en_n.z  = 1'b1;
      end
      OP_RL, OP_RR: begin
        res_n = rot_r;
      end
      OP_RLC, OP_RRC: begin
        res_n   = rot_r;
        flg_n.c = rot_c;
        en_n.c  = 1'b1;
      end
      OP_INC: begin
        res_n   = inc_r;
        flg_n.z = (inc_r == '0);
        en_n.z  = 1'b1;
      end
      OP_DEC: begin
        res_n   = dec_r;
        flg_n.z = (dec_r == '0);
        en_n.z  = 1'b1;
      end
      OP_SZ: begin
        res_n  = opd_i;
        skip_n = (opd_i == '0);
      end
      OP_SNZ: begin
        res_n  = opd_i;
        skip_n = (opd_i != '0);
      end
      OP_SIZ: begin
        res_n  = inc_r;
        skip_n = (inc_r == '0);
      end
      OP_SDZ: begin
        res_n  = dec_r;
        skip_n = (dec_r == '0);
      end
      default: begin
        res_n  = '0;
        flg_n  = '0;
        en_n   = '0;
        skip_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      c_o    <= 1'b0;
      ac_o   <= 1'b0;
      z_o    <= 1'b0;
      ov_o   <= 1'b0;
      upd_o  <= '0;
      skip_o <= 1'b0;
    end else begin
      res_o  <= res_n;
      c_o    <= flg_n.c;
      ac_o   <= flg_n.ac;
      z_o    <= flg_n.z;
      ov_o   <= flg_n.ov;
      upd_o  <= en_n;
      skip_o <= skip_n;
    end
  end

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] opd_i,
  input logic          c_i,
  input logic [DW-1:0] res_o,
  input logic          c_o,
  input logic          ac_o,
  input logic          z_o,
  input logic          ov_o,
  input logic [3:0]    upd_o,
  input logic          skip_o
);

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> (res_o == DW'($past(acc_i) + $past(opd_i))));

  // R3
  sub_noborrow_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SUB) |=> (c_o == ($past(acc_i) >= $past(opd_i))));

  // R6
  logic_zonly_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {OP_AND, OP_OR, OP_XOR, OP_CPL, OP_INC, OP_DEC}) |=> (upd_o == 4'b0010));

  // R7
  rot_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {OP_RL, OP_RR}) |=> (upd_o == 4'b0000));

  // R8
  rlc_out_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RLC) |=> (c_o == $past(opd_i[DW-1]) && res_o[0] == $past(c_i)));

  // R10
  sz_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SZ) |=> (skip_o == ($past(opd_i) == '0)));

  // R12
  gated_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !(( !upd_o[3] && c_o) || (!upd_o[2] && ac_o) || (!upd_o[1] && z_o) || (!upd_o[0] && ov_o)));

  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    upd_o[1] |-> (z_o == (res_o == '0)));

endmodule

bind alu8_core alu8_chk #(.DW(DW)) u_alu8_chk (
  .clk    (clk),
  .rst    (rst),
  .op_i   (op_i),
  .acc_i  (acc_i),
  .opd_i  (opd_i),
  .c_i    (c_i),
  .res_o  (res_o),
  .c_o    (c_o),
  .ac_o   (ac_o),
  .z_o    (z_o),
  .ov_o   (ov_o),
  .upd_o  (upd_o),
  .skip_o (skip_o)
);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0;
  logic [7:0] opd_i = '0;
  logic       c_i = 1'b0;
  logic       ac_i = 1'b0;
  logic [7:0] res_o;
  logic       c_o, ac_o, z_o, ov_o, skip_o;
  logic [3:0] upd_o;

  always #5 clk = ~clk;

  alu8_core #(.DW(8)) u_alu8_core (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i),
    .c_i(c_i), .ac_i(ac_i), .res_o(res_o), .c_o(c_o), .ac_o(ac_o),
    .z_o(z_o), .ov_o(ov_o), .upd_o(upd_o), .skip_o(skip_o)
  );

  int checks = 0;
  int fails  = 0;

  // {req, op, acc, opd, c_i, ac_i, res, flags{C,AC,Z,OV}, upd, skip}
  localparam int NV = 35;
  localparam logic [43:0] VEC [NV] = '{
    {4'd2,  5'd0,  8'h3A, 8'h26, 1'b0, 1'b0, 8'h60, 4'b0100, 4'b1111, 1'b0}, // R2
    {4'd4,  5'd0,  8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 4'b1011, 4'b1111, 1'b0}, // R4 C,Z,OV together
    {4'd4,  5'd0,  8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 4'b0101, 4'b1111, 1'b0}, // R4
    {4'd2,  5'd1,  8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 4'b1110, 4'b1111, 1'b0}, // R2
    {4'd2,  5'd1,  8'h12, 8'h34, 1'b0, 1'b0, 8'h46, 4'b0000, 4'b1111, 1'b0}, // R2
    {4'd3,  5'd2,  8'h50, 8'h20, 1'b0, 1'b0, 8'h30, 4'b1100, 4'b1111, 1'b0}, // R3
    {4'd3,  5'd2,  8'h20, 8'h50, 1'b1, 1'b0, 8'hD0, 4'b0100, 4'b1111, 1'b0}, // R3 borrow
    {4'd4,  5'd2,  8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 4'b1001, 4'b1111, 1'b0}, // R4
    {4'd3,  5'd2,  8'h33, 8'h33, 1'b0, 1'b0, 8'h00, 4'b1110, 4'b1111, 1'b0}, // R3
    {4'd3,  5'd3,  8'h10, 8'h01, 1'b0, 1'b0, 8'h0E, 4'b1000, 4'b1111, 1'b0}, // R3
    {4'd3,  5'd3,  8'h05, 8'h07, 1'b1, 1'b0, 8'hFE, 4'b0000, 4'b1111, 1'b0}, // R3
    {4'd5,  5'd4,  8'h3C, 8'h00, 1'b0, 1'b0, 8'h42, 4'b0000, 4'b1000, 1'b0}, // R5
    {4'd5,  5'd4,  8'h9A, 8'h00, 1'b0, 1'b0, 8'hA0, 4'b0000, 4'b1000, 1'b0}, // R5
    {4'd5,  5'd4,  8'hA5, 8'h00, 1'b0, 1'b0, 8'h05, 4'b1000, 4'b1000, 1'b0}, // R5
    {4'd5,  5'd4,  8'h12, 8'h00, 1'b1, 1'b1, 8'h78, 4'b0000, 4'b1000, 1'b0}, // R5
    {4'd6,  5'd5,  8'hF0, 8'h0F, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R6
    {4'd6,  5'd6,  8'hA0, 8'h05, 1'b1, 1'b0, 8'hA5, 4'b0000, 4'b0010, 1'b0}, // R6
    {4'd6,  5'd7,  8'h5A, 8'h5A, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R6
    {4'd6,  5'd8,  8'h12, 8'hFF, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R6
    {4'd7,  5'd9,  8'h00, 8'h81, 1'b1, 1'b0, 8'h03, 4'b0000, 4'b0000, 1'b0}, // R7
    {4'd7,  5'd10, 8'h00, 8'h01, 1'b0, 1'b0, 8'h80, 4'b0000, 4'b0000, 1'b0}, // R7
    {4'd8,  5'd11, 8'h00, 8'h80, 1'b0, 1'b0, 8'h00, 4'b1000, 4'b1000, 1'b0}, // R8
    {4'd8,  5'd12, 8'h00, 8'h02, 1'b1, 1'b0, 8'h81, 4'b0000, 4'b1000, 1'b0}, // R8
    {4'd8,  5'd12, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 4'b1000, 4'b1000, 1'b0}, // R8
    {4'd9,  5'd13, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R9
    {4'd9,  5'd14, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b0010, 1'b0}, // R9
    {4'd10, 5'd15, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b1}, // R10
    {4'd10, 5'd15, 8'h00, 8'h01, 1'b0, 1'b0, 8'h01, 4'b0000, 4'b0000, 1'b0}, // R10
    {4'd10, 5'd16, 8'h00, 8'h01, 1'b0, 1'b0, 8'h01, 4'b0000, 4'b0000, 1'b1}, // R10
    {4'd10, 5'd16, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0}, // R10
    {4'd11, 5'd17, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b1}, // R11
    {4'd11, 5'd17, 8'h00, 8'h00, 1'b0, 1'b0, 8'h01, 4'b0000, 4'b0000, 1'b0}, // R11
    {4'd11, 5'd18, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b1}, // R11
    {4'd11, 5'd18, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b0000, 1'b0}, // R11
    {4'd12, 5'd31, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'h00, 4'b0000, 4'b0000, 1'b0}  // R12
  };

  task automatic check(input string what, input int req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic ac);
    op_i = o; acc_i = a; opd_i = b; c_i = c; ac_i = ac;
  endtask

  function automatic logic [15:0] outs();
    return {res_o, c_o, ac_o, z_o, ov_o, upd_o};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    // R1: reset holds outputs at zero even with live inputs
    drive(5'd0, 8'hFF, 8'hFF, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check("reset outputs", 1, outs(), 16'h0000);
    check("reset skip", 1, {15'd0, skip_o}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][39:35], VEC[i][34:27], VEC[i][26:19], VEC[i][18], VEC[i][17]);
      @(negedge clk);
      check($sformatf("vec %0d result", i), int'(VEC[i][43:40]), {8'h00, res_o}, {8'h00, VEC[i][16:9]});
      check($sformatf("vec %0d flags", i), int'(VEC[i][43:40]), {12'h000, c_o, ac_o, z_o, ov_o}, {12'h000, VEC[i][8:5]});
      check($sformatf("vec %0d enables", i), int'(VEC[i][43:40]), {12'h000, upd_o}, {12'h000, VEC[i][4:1]});
      check($sformatf("vec %0d skip", i), int'(VEC[i][43:40]), {15'd0, skip_o}, {15'd0, VEC[i][0]});
    end

    // R6: complement ignores the accumulator
    @(negedge clk);
    drive(5'd8, 8'hFF, 8'h3C, 1'b0, 1'b0);
    @(negedge clk);
    check("cpl ignores acc", 6, {8'h00, res_o}, 16'h00C3);

    // R1: one-cycle latency with inputs changing every cycle
    drive(5'd0, 8'h01, 8'h02, 1'b0, 1'b0);
    @(negedge clk);
    check("latency first", 1, {8'h00, res_o}, 16'h0003);
    drive(5'd0, 8'h04, 8'h04, 1'b0, 1'b0);
    @(negedge clk);
    check("latency second", 1, {8'h00, res_o}, 16'h0008);

    // R1: reset asserted mid-run clears on the next edge
    drive(5'd0, 8'h80, 8'h80, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("mid reset", 1, outs(), 16'h0000);
    rst = 1'b0;

    // R11: decrement-and-skip on FFh does not skip
    drive(5'd18, 8'h00, 8'hFF, 1'b1, 1'b1);
    @(negedge clk);
    check("sdz no wrap", 11, {7'd0, skip_o, res_o}, 16'h00FE);

    // R7: plain rotate ignores incoming carry
    drive(5'd10, 8'h00, 8'h02, 1'b1, 1'b0);
    @(negedge clk);
    check("rr ignores carry", 7, {8'h00, res_o}, 16'h0001);

    finish_run();
  end

endmodule